// File: doc/BRIEF.md
# Built-In Logic Block Observer Register

This block is a four-stage test register that can sit between two pieces of logic and take on one of four roles, chosen by a two-bit mode input. In its functional role it loads a data word in parallel on each clock. In its scan role it forms a serial shift path from a scan input to a scan output. In its signature role it compresses a stream of parallel data words into a signature, using a linear feedback shift register with the characteristic polynomial 1 + x + x^4. In its fourth role it clears itself.

In the signature role, if the parallel inputs are held at zero, the register steps through a maximal-length pseudo-random sequence of 15 nonzero states. A register upstream of some logic can therefore generate patterns for that logic, while a second register downstream compresses its responses into a signature. That signature is then compared against a known-good value outside the block.

Top module: `bilbo_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes 0000, whatever the mode.
- R2: Mode 2'b01 (clear) makes the register 0000 at the next edge.
- R3: Mode 2'b11 (load) copies `d_i` into the register at the next edge.
- R4: Mode 2'b00 (scan) shifts the register one place toward the high end at each edge. Bit 0 takes `scan_i` and bit k takes the old bit k-1.
- R5: `scan_o` equals register bit 3 in every mode.
- R6: Mode 2'b10 (signature) updates each bit as follows, where q3 is the old top bit:
  - bit0 <= q3 ^ d0
  - bit1 <= q0 ^ q3 ^ d1
  - bit2 <= q1 ^ d2
  - bit3 <= q2 ^ d3
- R7: In signature mode with `d_i` held at 0000 and a nonzero starting value, the register passes through all 15 nonzero values before it returns to the start, and it never reaches 0000.
- R8: After a stream of N data words in signature mode, the register matches a reference model of R6. A stream that differs from it in exactly one bit gives a different signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Role select: 00 scan, 01 clear, 10 signature, 11 load |
| d_i | input | 4 | Parallel data input |
| scan_i | input | 1 | Serial scan input into bit 0 |
| q_o | output | 4 | Register contents |
| scan_o | output | 1 | Serial scan output, the top register bit |

## Verification
The bench goes after the feedback tap. A register with the tap on the wrong stage, or with no tap at all, still changes state in signature mode, but it leaves the 15-state cycle early or falls into a shorter loop, so the coverage check over a full period catches it. Shift direction is tested with an asymmetric serial pattern; a chain wired the wrong way shows that pattern reversed on `scan_o`. Reset is applied with load mode and all-ones data on the inputs, so a reset that does not override the mode loads 1111 instead of clearing. A one-bit difference between two compressed streams must change the signature; a register that drops a data input would give the same signature for both streams.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

    typedef enum logic [1:0] {
        MODE_SCAN  = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_SIG   = 2'b10,
        MODE_LOAD  = 2'b11
    } bilbo_mode_e;

    // Feedback contribution of the top stage into one stage, given a tap mask.
    function automatic logic tap_feedback(input logic tap_en, input logic top_bit);
        return tap_en & top_bit;
    endfunction

endpackage

// File: rtl/bilbo_head_mux.sv
module bilbo_head_mux
    import bilbo_pkg::*;
(
    input  bilbo_mode_e mode_i,
    input  logic        scan_i,
    input  logic        fb_i,
    output logic        head_o
);

    // Serial input in scan role, loop feedback otherwise.
    always_comb begin
        head_o = (mode_i == MODE_SCAN) ? scan_i : fb_i;
    end

endmodule

// File: rtl/bilbo_cell.sv
module bilbo_cell
    import bilbo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bilbo_mode_e mode_i,
    input  logic        prev_i,
    input  logic        d_i,
    input  logic        tap_i,
    output logic        q_o
);

    logic nxt;

    always_comb begin
        unique case (mode_i)
            MODE_SCAN:  nxt = prev_i;
            MODE_CLEAR: nxt = 1'b0;
            MODE_SIG:   nxt = prev_i ^ d_i ^ tap_i;
            MODE_LOAD:  nxt = d_i;
            default:    nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= nxt;
    end

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int               WIDTH = 4,
    parameter logic [WIDTH-1:0] TAPS  = 4'b0010
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic             scan_i,
    output logic [WIDTH-1:0] q_o,
    output logic             scan_o
);

    localparam int TOP = WIDTH - 1;

    bilbo_mode_e      mode;
    logic [WIDTH-1:0] q;
    logic             head;

    assign mode = bilbo_mode_e'(mode_i);

    bilbo_head_mux u_head (
        .mode_i (mode),
        .scan_i (scan_i),
        .fb_i   (q[TOP]),
        .head_o (head)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic prev;
        logic tap;
        if (i == 0) begin : g_first
            assign prev = head;
            assign tap  = 1'b0;
        end else begin : g_rest
            assign prev = q[i-1];
            assign tap  = tap_feedback(TAPS[i], q[TOP]);
        end
        bilbo_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .mode_i (mode),
            .prev_i (prev),
            .d_i    (d_i[i]),
            .tap_i  (tap),
            .q_o    (q[i])
        );
    end

    assign q_o    = q;
    assign scan_o = q[TOP];

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b01 |=> q_o == '0);

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b11 |=> q_o == $past(d_i));

    // R4
    scan_shift_chk: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b00 |=> q_o == {$past(q_o[WIDTH-2:0]), $past(scan_i)});

    // R7
    prsg_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10 && d_i == '0 && q_o != '0) |=> q_o != '0);

endmodule

// File: tb/sim_bilbo_reg.sv
module sim_bilbo_reg;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic [3:0] d;
    logic       si;
    logic [3:0] q;
    logic       so;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] model = 4'h0;

    always #4 clk = ~clk;   // 125 MHz

    bilbo_reg u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .d_i(d),
        .scan_i(si), .q_o(q), .scan_o(so)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Reference next value, written from the requirements.
    function automatic logic [3:0] ref_next(input logic r, input logic [1:0] m,
                                            input logic [3:0] s, input logic [3:0] din,
                                            input logic sin);
        logic [3:0] n;
        if (r) return 4'h0;
        case (m)
            2'b00: n = {s[2:0], sin};
            2'b01: n = 4'h0;
            2'b11: n = din;
            default: begin
                n[0] = s[3] ^ din[0];
                n[1] = s[0] ^ s[3] ^ din[1];
                n[2] = s[1] ^ din[2];
                n[3] = s[2] ^ din[3];
            end
        endcase
        return n;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic step(input logic r, input logic [1:0] m, input logic [3:0] din,
                        input logic sin, input string req);
        rst = r; mode = m; d = din; si = sin;
        model = ref_next(r, m, model, din, sin);
        exp_q.push_back(model);
        tag_q.push_back(req);
        @(posedge clk);
        #4;
    endtask

    // Monitor: compares register and scan output after each edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, q, e);
            check("R5", {3'b0, so}, {3'b0, e[3]});
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [3:0] sig_a, sig_b, seed;
        logic [15:0] seen;
        int distinct;
        rst = 1'b1; mode = 2'b11; d = 4'hF; si = 1'b0;
        #2;
        // R1: reset overrides load of 1111
        step(1'b1, 2'b11, 4'hF, 1'b1, "R1");
        step(1'b1, 2'b10, 4'hA, 1'b1, "R1");
        // R3: loads of several words
        step(1'b0, 2'b11, 4'hA, 1'b0, "R3");
        step(1'b0, 2'b11, 4'h5, 1'b1, "R3");
        step(1'b0, 2'b11, 4'hF, 1'b0, "R3");
        // R2: clear from all ones
        step(1'b0, 2'b01, 4'h7, 1'b1, "R2");
        // R4: shift in 1,0,1,1 then flush out with zeros (R5 on scan_o)
        step(1'b0, 2'b00, 4'hF, 1'b1, "R4");
        step(1'b0, 2'b00, 4'h0, 1'b0, "R4");
        step(1'b0, 2'b00, 4'hF, 1'b1, "R4");
        step(1'b0, 2'b00, 4'h0, 1'b1, "R4");
        for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 4'h0, 1'b0, "R4_out");
        // R6: single signature steps from chosen states
        step(1'b0, 2'b11, 4'h8, 1'b0, "R3");
        step(1'b0, 2'b10, 4'h0, 1'b0, "R6");
        step(1'b0, 2'b11, 4'h9, 1'b0, "R3");
        step(1'b0, 2'b10, 4'h6, 1'b1, "R6");
        // R7: full pseudo-random period from seed 0001
        seed = 4'h1;
        step(1'b0, 2'b11, seed, 1'b0, "R3");
        seen = '0; distinct = 0;
        for (int i = 0; i < 15; i++) begin
            step(1'b0, 2'b10, 4'h0, 1'b0, "R7");
            if (q == 4'h0) check("R7_zero", q, 4'h1);
            if (!seen[q]) distinct++;
            seen[q] = 1'b1;
            if (i < 14 && q == seed) check("R7_early", q, ~seed);
        end
        check("R7_distinct", distinct[3:0], 4'hF);
        check("R7_return", q, seed);
        // R8: compress a stream, then the same stream with one bit flipped
        step(1'b0, 2'b01, 4'h0, 1'b0, "R2");
        for (int i = 0; i < 20; i++) step(1'b0, 2'b10, 4'((i * 7 + 3) & 15), 1'b0, "R8");
        sig_a = q;
        check("R8_model", sig_a, model);
        step(1'b0, 2'b01, 4'h0, 1'b0, "R2");
        for (int i = 0; i < 20; i++) begin
            logic [3:0] w;
            w = 4'((i * 7 + 3) & 15);
            if (i == 5) w = w ^ 4'h4;
            step(1'b0, 2'b10, w, 1'b0, "R8");
        end
        sig_b = q;
        check("R8_differ", {3'b0, sig_a != sig_b}, 4'h1);
        // R1 again mid-run
        step(1'b1, 2'b00, 4'h0, 1'b1, "R1");
        #10;
        finish_run();
    end

endmodule